// File: doc/BRIEF.md
# Serial ADC power-mode pulse decoder

This block models the power-management logic of a serial sampling converter. It runs on a fast system clock and sees two slave-side inputs: a conversion-start strobe and the serial data clock. Both are synchronised, and their rising edges are detected. Power commands carry no pins of their own. A host commands a power mode by strobing the conversion input a set number of times while the serial clock is held low. Two strobes select nap, where the reference keeps running. Four strobes select sleep, where the reference is switched off as well.

A clean high pulse on the serial clock brings the block back to the active state. After a nap the block waits a short tick count before it allows conversions again. After a sleep the reference first has to settle, so the reference-ready flag stays low for a much longer tick count. A conversion strobe that arrives too soon after a serial-clock rise breaks the timing rules. Such a strobe locks out further conversion starts. The lock lasts until a nap command returns the block to a known state.

Top module: `pmd_power_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (active), `ref_en_o`, `ref_rdy_o` and `conv_ok_o` are 1, and a conversion may start.
- R2: Two conversion-strobe rising edges while the serial clock stays low set `mode_o` to 2'b01 (nap). In nap, `ref_en_o` and `ref_rdy_o` stay 1 and `conv_ok_o` is 0. Fewer than two strobes leave the mode at 2'b00.
- R3: A third strobe in the same low-clock run keeps nap. The fourth sets `mode_o` to 2'b10 (sleep). Further strobes leave sleep in force.
- R4: In sleep, `ref_en_o` and `ref_rdy_o` are both 0.
- R5: Wake-up from nap or sleep needs the serial clock high for at least MIN_HIGH consecutive system ticks. A shorter high pulse leaves `mode_o` unchanged.
- R6: After a nap wake-up, `mode_o` reads 2'b00 at once and `ref_rdy_o` stays 1. `conv_ok_o` returns to 1 only after NAP_WAKE_TICKS ticks.
- R7: After a sleep wake-up, `ref_en_o` is 1 and `mode_o` is 2'b00, but `ref_rdy_o` and `conv_ok_o` stay 0 for SLEEP_WAKE_TICKS ticks before going to 1.
- R8: Each strobe rising edge in the active, ready, unlocked state gives one single-cycle `conv_start_o` pulse. Strobes in nap, sleep or during a wake-up give none.
- R9: Every serial-clock rise clears the strobe count, so strobe runs split by a clock pulse never add up to a mode change.
- R10: A strobe rising edge fewer than GUARD_TICKS ticks after a serial-clock rise, while active, locks the block. From then on `conv_ok_o` is 0 and strobes produce no `conv_start_o`.
- R11: Entering nap clears the lock. After the following wake-up, conversions start normally again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion-start strobe, asynchronous |
| sclk_i | input | 1 | Serial data clock, asynchronous |
| mode_o | output | 2 | Power mode: 00 active, 01 nap, 10 sleep |
| ref_en_o | output | 1 | Reference enable |
| ref_rdy_o | output | 1 | Reference settled flag |
| conv_ok_o | output | 1 | Conversions currently accepted |
| conv_start_o | output | 1 | One-tick pulse per accepted conversion start |

## Verification
The bench targets four kinds of behaviour. The first is the strobe counts around each threshold: one, two, three, four and more strobes. A counter off by one here picks the wrong mode or skips nap on the way to sleep. The second is a run of strobes split by a short serial-clock pulse, which a design that keeps its count would wrongly turn into nap. The third is a high pulse shorter than the wake width, which a design that wakes on any edge would answer by leaving nap. The fourth is a strobe that lands too soon after a clock rise. A design without the lock would keep starting conversions there, and one that never clears the lock would stay dead after the nap command.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_NAP    = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_WAKE   = 3'd3,
        ST_WARM   = 3'd4
    } pwr_state_t;

    localparam logic [1:0] MODE_ACTIVE = 2'b00;
    localparam logic [1:0] MODE_NAP    = 2'b01;
    localparam logic [1:0] MODE_SLEEP  = 2'b10;

endpackage

// File: rtl/pmd_sync_edge.sv
module pmd_sync_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = async_i;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign level_o[i] = q.s2[i];
        assign rise_o[i]  = q.s2[i] & ~q.prev[i];
    end

endmodule

// File: rtl/pmd_strobe_counter.sv
module pmd_strobe_counter #(
    parameter int SAT = 4,
    localparam int CW = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          strobe_rise_i,
    input  logic          sclk_level_i,
    input  logic          sclk_rise_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sclk_rise_i)
            cnt_d = '0;
        else if (en_i && strobe_rise_i && !sclk_level_i && (cnt_q < CW'(SAT)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9: a serial-clock rise leaves the count empty on the next tick
    a_r9_clear_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sclk_rise_i) |-> (cnt_q == '0));

    // R3: the count never passes the sleep threshold
    a_r3_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SAT));

endmodule

// File: rtl/pmd_tick_timer.sv
module pmd_tick_timer #(
    parameter int MAX_TICKS = 1000,
    localparam int TW = $clog2(MAX_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] value_i,
    output logic          done_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = value_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R6: without a reload the settle count drops by exactly one per tick
    a_r6_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pmd_power_ctrl.sv
module pmd_power_ctrl #(
    parameter int NAP_PULSES       = 2,
    parameter int SLEEP_PULSES     = 4,
    parameter int MIN_HIGH         = 4,
    parameter int GUARD_TICKS      = 4,
    parameter int NAP_WAKE_TICKS   = 70,
    parameter int SLEEP_WAKE_TICKS = 800000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_i,
    input  logic       sclk_i,
    output logic [1:0] mode_o,
    output logic       ref_en_o,
    output logic       ref_rdy_o,
    output logic       conv_ok_o,
    output logic       conv_start_o
);
    import pmd_pkg::*;

    localparam int CW = $clog2(SLEEP_PULSES + 1);
    localparam int TW = $clog2(SLEEP_WAKE_TICKS + 1);
    localparam int GW = $clog2(GUARD_TICKS + 1);
    localparam int HW = $clog2(MIN_HIGH + 1);
    localparam int IDX_CONV = 0;
    localparam int IDX_SCLK = 1;

    logic [1:0]    lvl, rise;
    logic          conv_rise, sclk_rise, sclk_lvl;
    logic [CW-1:0] pulse_cnt;
    logic          count_en;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          wake_req, too_soon;

    typedef struct packed {
        pwr_state_t    st;
        logic [GW-1:0] since;
        logic [HW-1:0] hi;
        logic          lock;
    } ctl_t;

    ctl_t q, d;

    pmd_sync_edge #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, conv_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    assign conv_rise = rise[IDX_CONV];
    assign sclk_rise = rise[IDX_SCLK];
    assign sclk_lvl  = lvl[IDX_SCLK];

    assign count_en = (q.st == ST_ACTIVE) || (q.st == ST_NAP);

    pmd_strobe_counter #(.SAT(SLEEP_PULSES)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (count_en),
        .strobe_rise_i (conv_rise),
        .sclk_level_i  (sclk_lvl),
        .sclk_rise_i   (sclk_rise),
        .cnt_o         (pulse_cnt)
    );

    pmd_tick_timer #(.MAX_TICKS(SLEEP_WAKE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .done_o  (tmr_done)
    );

    assign wake_req = sclk_lvl && (q.hi == HW'(MIN_HIGH - 1));
    assign too_soon = q.since < GW'(GUARD_TICKS);

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        if (sclk_rise)
            d.since = '0;
        else if (too_soon)
            d.since = q.since + 1'b1;

        if (!sclk_lvl)
            d.hi = '0;
        else if (q.hi < HW'(MIN_HIGH))
            d.hi = q.hi + 1'b1;

        if (q.st == ST_ACTIVE && conv_rise && too_soon)
            d.lock = 1'b1;

        unique case (q.st)
            ST_ACTIVE: begin
                if (pulse_cnt >= CW'(SLEEP_PULSES))
                    d.st = ST_SLEEP;
                else if (pulse_cnt >= CW'(NAP_PULSES)) begin
                    d.st   = ST_NAP;
                    d.lock = 1'b0;
                end
            end
            ST_NAP: begin
                if (wake_req) begin
                    d.st     = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(NAP_WAKE_TICKS);
                end else if (pulse_cnt >= CW'(SLEEP_PULSES))
                    d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_req) begin
                    d.st     = ST_WARM;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SLEEP_WAKE_TICKS);
                end
            end
            ST_WAKE, ST_WARM: begin
                if (tmr_done)
                    d.st = ST_ACTIVE;
            end
            default: d.st = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_ACTIVE;
            q.since <= GW'(GUARD_TICKS);
            q.hi    <= '0;
            q.lock  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_NAP:   mode_o = MODE_NAP;
            ST_SLEEP: mode_o = MODE_SLEEP;
            default:  mode_o = MODE_ACTIVE;
        endcase
    end

    assign ref_en_o     = (q.st != ST_SLEEP);
    assign ref_rdy_o    = (q.st != ST_SLEEP) && (q.st != ST_WARM);
    assign conv_ok_o    = (q.st == ST_ACTIVE) && !q.lock;
    assign conv_start_o = conv_ok_o && conv_rise && !too_soon;

    // R4: reference off whenever sleep is reported
    a_r4_sleep_ref_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> !ref_en_o);

    // R7: a settled reference implies an enabled one
    a_r7_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rdy_o |-> ref_en_o);

    // R8: start pulses only while conversions are accepted
    a_r8_start_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> conv_ok_o);

    // R2: nap is only reached from active after enough strobes
    a_r2_nap_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NAP && $past(q.st) == ST_ACTIVE) |-> ($past(pulse_cnt) >= CW'(NAP_PULSES)));

    // R11: the lock never survives into nap
    a_r11_nap_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NAP) |-> !q.lock);

    // R5: leaving nap or sleep happens only with the serial clock high
    a_r5_wake_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_SLEEP && q.st == ST_WARM) |-> $past(sclk_lvl));

endmodule

// File: tb/pmd_power_ctrl_tb.sv
module pmd_power_ctrl_tb;

    localparam int MIN_HIGH  = 4;
    localparam int GUARD     = 4;
    localparam int NAP_WAKE  = 20;
    localparam int SLEEP_WAK = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic [1:0] mode_o;
    logic       ref_en_o, ref_rdy_o, conv_ok_o, conv_start_o;

    int vectors = 0;
    int misses  = 0;
    int starts  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pmd_power_ctrl #(
        .NAP_PULSES(2), .SLEEP_PULSES(4), .MIN_HIGH(MIN_HIGH),
        .GUARD_TICKS(GUARD), .NAP_WAKE_TICKS(NAP_WAKE),
        .SLEEP_WAKE_TICKS(SLEEP_WAK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sclk_i(sclk_i),
        .mode_o(mode_o), .ref_en_o(ref_en_o), .ref_rdy_o(ref_rdy_o),
        .conv_ok_o(conv_ok_o), .conv_start_o(conv_start_o)
    );

    always @(negedge clk) if (rst_n && conv_start_o) starts++;

    function automatic int exp_mode(int pulses);
        if (pulses >= 4) return 2;
        if (pulses >= 2) return 1;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        conv_i = 1'b1; ticks(3);
        conv_i = 1'b0; ticks(3);
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) strobe();
        ticks(4);
    endtask

    task automatic clk_pulse(int width);
        sclk_i = 1'b1; ticks(width);
        sclk_i = 1'b0; ticks(GUARD + 4);
    endtask

    task automatic wake_full();
        clk_pulse(MIN_HIGH + 2);
        ticks(SLEEP_WAK + 10);
    endtask

    initial begin
        int s0;
        void'($urandom(32'd2024));
        ticks(3);
        rst_n = 1'b1;
        ticks(2);

        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 ref_en", ref_en_o, 1);
        chk("R1 ref_rdy", ref_rdy_o, 1);
        chk("R1 conv_ok", conv_ok_o, 1);

        // R8 single strobe starts one conversion
        s0 = starts;
        strobes(1);
        chk("R8 start count", starts - s0, 1);
        chk("R2 one strobe stays active", mode_o, 0);
        clk_pulse(2);

        // R9 split runs do not add up
        strobe();
        clk_pulse(2);
        strobes(1);
        chk("R9 split run mode", mode_o, 0);
        clk_pulse(2);

        // R2 nap entry
        strobes(2);
        chk("R2 nap mode", mode_o, 1);
        chk("R2 nap ref_en", ref_en_o, 1);
        chk("R2 nap ref_rdy", ref_rdy_o, 1);
        chk("R2 nap conv_ok", conv_ok_o, 0);

        // R3 third strobe keeps nap, R8 no start in nap
        s0 = starts;
        strobes(1);
        chk("R3 third strobe nap", mode_o, 1);
        chk("R8 no start in nap", starts - s0, 0);

        // R5 short high pulse does not wake (also clears count, R9)
        clk_pulse(MIN_HIGH - 2);
        chk("R5 short pulse keeps nap", mode_o, 1);

        // R3 escalate from nap to sleep with four fresh strobes
        strobes(4);
        chk("R3 sleep mode", mode_o, 2);
        chk("R4 sleep ref_en", ref_en_o, 0);
        chk("R4 sleep ref_rdy", ref_rdy_o, 0);
        strobes(2);
        chk("R3 extra strobes keep sleep", mode_o, 2);
        clk_pulse(MIN_HIGH - 2);
        chk("R5 short pulse keeps sleep", mode_o, 2);

        // R7 sleep wake timing
        sclk_i = 1'b1; ticks(MIN_HIGH + 2);
        sclk_i = 1'b0; ticks(SLEEP_WAK - (MIN_HIGH + 2));
        chk("R7 mode during warm", mode_o, 0);
        chk("R7 ref_en during warm", ref_en_o, 1);
        chk("R7 ref_rdy during warm", ref_rdy_o, 0);
        chk("R7 conv_ok during warm", conv_ok_o, 0);
        ticks(MIN_HIGH + 8);
        chk("R7 ref_rdy after warm", ref_rdy_o, 1);
        chk("R7 conv_ok after warm", conv_ok_o, 1);

        // R6 nap wake timing
        strobes(2);
        chk("R6 in nap", mode_o, 1);
        sclk_i = 1'b1; ticks(MIN_HIGH + 2);
        sclk_i = 1'b0; ticks(NAP_WAKE - (MIN_HIGH + 2));
        chk("R6 mode after nap wake", mode_o, 0);
        chk("R6 ref_rdy kept", ref_rdy_o, 1);
        chk("R6 conv_ok during wake", conv_ok_o, 0);
        ticks(MIN_HIGH + 8);
        chk("R6 conv_ok after wake", conv_ok_o, 1);

        // R10 strobe too soon after a clock rise locks
        s0 = starts;
        sclk_i = 1'b1; ticks(1);
        strobe();
        sclk_i = 1'b0; ticks(GUARD + 4);
        chk("R10 no start on violation", starts - s0, 0);
        chk("R10 conv_ok locked", conv_ok_o, 0);
        strobes(1);
        chk("R10 later strobe ignored", starts - s0, 0);
        chk("R10 still active", mode_o, 0);
        // R11 nap request clears the lock
        strobes(1);
        chk("R11 nap reached", mode_o, 1);
        wake_full();
        chk("R11 conv_ok restored", conv_ok_o, 1);
        s0 = starts;
        strobes(1);
        chk("R11 start after unlock", starts - s0, 1);
        clk_pulse(2);

        // random strobe counts from active
        for (int t = 0; t < 30; t++) begin
            int k;
            k = $urandom_range(0, 6);
            strobes(k);
            chk("R3 random mode", mode_o, exp_mode(k));
            chk("R4 random ref_en", ref_en_o, (exp_mode(k) == 2) ? 0 : 1);
            wake_full();
            chk("R6 random back active", mode_o, 0);
            chk("R7 random ready", ref_rdy_o, 1);
        end

        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 150000) begin
            @(negedge clk);
            wd++;
        end
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule